// File: doc/BRIEF.md
# Sampled Quadrature Position Decoder

This block turns the two phase signals of an incremental encoder into a signed position value. Both phases are first brought into the system clock domain. A programmable divider then picks the instants at which the pair is examined. Every legal phase transition seen between two such instants moves the position by exactly one count, so the count rate is four times the per-phase signal frequency.

If both phases are found to have changed between two consecutive samples, the step direction cannot be known. The decoder does not guess. It leaves the position alone and latches a sticky error flag, which only an explicit clear strobe removes. Because of this, an encoder that runs faster than the sample rate allows shows up as a reported fault rather than as silently lost counts. The error-free limit is reached when the pair can advance by more than one state between samples. The ideal maximum count rate is therefore just under the sample rate.

A synchronous load presets the position. A polarity select chooses which rotation sense counts upward. A decode enable lets the block track the phases without counting them.

Top module: `quad_decoder`

## Requirements
- R1: After reset, `position` is 0 and `countError` is 0.
- R2: With `dirInvert`=0, the state pair {chanA,chanB} moving in the order 00→01→11→10→00 adds one to `position` per transition.
- R3: With `dirInvert`=0, the reverse order 00→10→11→01→00 subtracts one per transition.
- R4: With `dirInvert`=1, the meanings of R2 and R3 are swapped: 00→01 subtracts one.
- R5: When both phases differ from the previous sample, `countError` goes to 1 and `position` is unchanged. The new pair becomes the reference, so the next single step counts from it.
- R6: `countError` stays 1 through later valid steps until `errClear` is pulsed. It is then 0.
- R7: If `errClear` is high in the same cycle that a new double change is detected, `countError` stays 1.
- R8: While `decodeEn` is 0, neither `position` nor `countError` changes, but the reference pair keeps following the inputs. Phase moves made while disabled are therefore not counted after re-enabling.
- R9: `loadEn` writes `loadValue` into `position` on the next edge and overrides any step detected in that cycle.
- R10: `position` is CNT_W-bit two's complement and wraps: one up-step from all ones gives 0, and one up-step from 0x7FFFFFFF gives 0x80000000.
- R11: The phases are sampled once every `divisor` clock cycles, and a `divisor` of 0 behaves as 1. A single step becomes visible on `position` at most divisor+3 cycles after the input changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| chanA | input | 1 | Raw phase A (pair bit 1) |
| chanB | input | 1 | Raw phase B (pair bit 0) |
| divisor | input | DIV_W | Sample divider; 0 or 1 samples every cycle |
| decodeEn | input | 1 | Enables counting and error detection |
| dirInvert | input | 1 | Swaps the up and down rotation sense |
| errClear | input | 1 | Clears the sticky error flag |
| loadEn | input | 1 | Synchronous position preset strobe |
| loadValue | input | CNT_W | Value written by the preset |
| position | output | CNT_W | Signed position count |
| countError | output | 1 | Sticky double-change flag |

## Verification
The bench uses the defaults CNT_W=32, DIV_W=8 and SYNC_STAGES=2. At CNT_W=32, the wrap points at all ones and at the signed maximum can be reached at once through the preset. Most stimulus runs at a divisor of 1, which makes the synchronizer-plus-sample latency exactly three edges. That fixed latency lets the clear-versus-set collision be aimed at a single cycle. Divisors of 4 and 0 are then applied to show that slower sampling still counts spaced steps and that 0 falls back to every-cycle sampling.

// File: rtl/quad_pkg.sv
package quad_pkg;
  // Strobes handed from the sampling control to the counting datapath.
  typedef struct packed {
    logic stepUp;
    logic stepDown;
    logic dblChange;
  } quadStrobe_t;
endpackage

// File: rtl/quad_ctrl.sv
module quad_ctrl
  import quad_pkg::*;
#(
  parameter int DIV_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             chanA,
  input  logic             chanB,
  input  logic [DIV_W-1:0] divisor,
  input  logic             decodeEn,
  input  logic             dirInvert,
  output quadStrobe_t      strobe
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [1:0]       syncPipe [SYNC_STAGES];
  logic [1:0]       prevPair;
  logic [1:0]       curPair;
  logic [DIV_W-1:0] divCnt;
  logic [DIV_W-1:0] effDiv;
  logic             sampleTick;
  logic             fwdStep, bwdStep, bothMoved;

  // Synchronizer chain, one register per stage.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncPipe[0] <= 2'b00;
    else       syncPipe[0] <= {chanA, chanB};
  end

  generate
    for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncPipe[s] <= 2'b00;
        else       syncPipe[s] <= syncPipe[s-1];
      end
    end
  endgenerate

  assign curPair = syncPipe[LAST];

  // Sample-instant divider; a zero divisor is treated as one.
  assign effDiv     = (divisor == '0) ? DIV_W'(1) : divisor;
  assign sampleTick = (divCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           divCnt <= '0;
    else if (sampleTick) divCnt <= effDiv - DIV_W'(1);
    else                 divCnt <= divCnt - DIV_W'(1);
  end

  // Reference pair follows every sample, also while decoding is off.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           prevPair <= 2'b00;
    else if (sampleTick) prevPair <= curPair;
  end

  function automatic logic [1:0] grayNext(input logic [1:0] st);
    case (st)
      2'b00:   return 2'b01;
      2'b01:   return 2'b11;
      2'b11:   return 2'b10;
      default: return 2'b00;
    endcase
  endfunction

  assign fwdStep   = (curPair == grayNext(prevPair));
  assign bwdStep   = (prevPair == grayNext(curPair));
  assign bothMoved = (curPair == ~prevPair);

  always_comb begin
    strobe           = '0;
    if (sampleTick && decodeEn) begin
      strobe.stepUp    = dirInvert ? bwdStep : fwdStep;
      strobe.stepDown  = dirInvert ? fwdStep : bwdStep;
      strobe.dblChange = bothMoved;
    end
  end
endmodule

// File: rtl/quad_datapath.sv
module quad_datapath
  import quad_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  quadStrobe_t      strobe,
  input  logic             loadEn,
  input  logic [CNT_W-1:0] loadValue,
  input  logic             errClear,
  output logic [CNT_W-1:0] position,
  output logic             countError
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                position <= '0;
    else if (loadEn)          position <= loadValue;
    else if (strobe.stepUp)   position <= position + ONE;
    else if (strobe.stepDown) position <= position - ONE;
  end

  // A fresh double change outranks a clear arriving in the same cycle.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 countError <= 1'b0;
    else if (strobe.dblChange) countError <= 1'b1;
    else if (errClear)         countError <= 1'b0;
  end
endmodule

// File: rtl/quad_decoder.sv
module quad_decoder
  import quad_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int DIV_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             chanA,
  input  logic             chanB,
  input  logic [DIV_W-1:0] divisor,
  input  logic             decodeEn,
  input  logic             dirInvert,
  input  logic             errClear,
  input  logic             loadEn,
  input  logic [CNT_W-1:0] loadValue,
  output logic [CNT_W-1:0] position,
  output logic             countError
);
  quadStrobe_t strobe;

  quad_ctrl #(.DIV_W(DIV_W), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .chanA(chanA), .chanB(chanB),
    .divisor(divisor), .decodeEn(decodeEn), .dirInvert(dirInvert),
    .strobe(strobe)
  );

  quad_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .loadEn(loadEn),
    .loadValue(loadValue), .errClear(errClear),
    .position(position), .countError(countError)
  );
endmodule

// File: rtl/quad_decoder_chk.sv
module quad_decoder_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             decodeEn,
  input logic             errClear,
  input logic             loadEn,
  input logic [CNT_W-1:0] loadValue,
  input logic [CNT_W-1:0] position,
  input logic             countError
);
  // R6: the flag holds unless a clear is applied
  a_r6_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (countError && !errClear) |=> countError);

  // R9: preset value appears on the next edge
  a_r9_load: assert property (@(posedge clk) disable iff (!rstN)
    loadEn |=> (position == $past(loadValue)));

  // R2/R3: without a preset the count moves by at most one per cycle
  a_r2_single_step: assert property (@(posedge clk) disable iff (!rstN)
    !loadEn |=> ((position == $past(position)) ||
                 (position == $past(position) + CNT_W'(1)) ||
                 (position == $past(position) - CNT_W'(1))));

  // R8: disabled decoding leaves the count alone
  a_r8_hold_disabled: assert property (@(posedge clk) disable iff (!rstN)
    (!decodeEn && !loadEn) |=> $stable(position));

  // R8: disabled decoding never raises the flag
  a_r8_no_err_disabled: assert property (@(posedge clk) disable iff (!rstN)
    (!decodeEn && !countError) |=> !countError);

  // R5: a newly raised flag comes with an unchanged count
  a_r5_err_no_count: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(countError) && !$past(loadEn)) |-> $stable(position));
endmodule

bind quad_decoder quad_decoder_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .decodeEn(decodeEn), .errClear(errClear),
  .loadEn(loadEn), .loadValue(loadValue), .position(position),
  .countError(countError)
);

// File: tb/quad_decoder_tb.sv
module quad_decoder_tb;
  localparam int CNT_W = 32;
  localparam int DIV_W = 8;
  localparam int NVEC  = 10;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             chanA = 1'b0, chanB = 1'b0;
  logic [DIV_W-1:0] divisor = DIV_W'(1);
  logic             decodeEn = 1'b1, dirInvert = 1'b0;
  logic             errClear = 1'b0, loadEn = 1'b0;
  logic [CNT_W-1:0] loadValue = '0;
  logic [CNT_W-1:0] position;
  logic             countError;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  quad_decoder #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_dut (
    .clk(clk), .rstN(rstN), .chanA(chanA), .chanB(chanB),
    .divisor(divisor), .decodeEn(decodeEn), .dirInvert(dirInvert),
    .errClear(errClear), .loadEn(loadEn), .loadValue(loadValue),
    .position(position), .countError(countError)
  );

  // Vector: {pair AB, expected position, expected flag, requirement number}
  typedef struct packed {
    logic [1:0]  ab;
    logic [31:0] expPos;
    logic        expErr;
    logic [7:0]  req;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{2'b01, 32'd1, 1'b0, 8'd2},  // R2 forward
    '{2'b11, 32'd2, 1'b0, 8'd2},
    '{2'b10, 32'd3, 1'b0, 8'd2},
    '{2'b00, 32'd4, 1'b0, 8'd2},
    '{2'b10, 32'd3, 1'b0, 8'd3},  // R3 reverse
    '{2'b11, 32'd2, 1'b0, 8'd3},
    '{2'b01, 32'd1, 1'b0, 8'd3},
    '{2'b00, 32'd0, 1'b0, 8'd3},
    '{2'b11, 32'd0, 1'b1, 8'd5},  // R5 double change
    '{2'b10, 32'd1, 1'b1, 8'd6}   // R6 flag kept, step from new reference
  };

  task automatic check(input string tag, input logic [CNT_W-1:0] expPos,
                       input logic expErr);
    checks++;
    if (position !== expPos || countError !== expErr) begin
      failures++;
      $display("FAIL %s pos=%0h err=%0b expected pos=%0h err=%0b",
               tag, position, countError, expPos, expErr);
    end
  endtask

  task automatic drivePair(input logic [1:0] ab);
    @(negedge clk);
    {chanA, chanB} = ab;
    repeat (8) @(negedge clk);
  endtask

  task automatic pulseClear();
    @(negedge clk); errClear = 1'b1;
    @(negedge clk); errClear = 1'b0;
  endtask

  task automatic preset(input logic [CNT_W-1:0] v);
    @(negedge clk); loadEn = 1'b1; loadValue = v;
    @(negedge clk); loadEn = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", '0, 1'b0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 after release", '0, 1'b0);

    for (int i = 0; i < NVEC; i++) begin
      drivePair(VECS[i].ab);
      check($sformatf("R%0d vector %0d", VECS[i].req, i),
            VECS[i].expPos, VECS[i].expErr);
    end

    // R6: clear drops the flag
    pulseClear();
    repeat (2) @(negedge clk);
    check("R6 clear", 32'd1, 1'b0);

    // R4: inverted sense, pair is 10 now; 10->00 is forward
    dirInvert = 1'b1;
    drivePair(2'b00);
    check("R4 inverted forward", 32'd0, 1'b0);
    drivePair(2'b01);
    check("R4 inverted 00->01", 32'hFFFF_FFFF, 1'b0);
    dirInvert = 1'b0;

    // R10: wrap from all ones, pair is 01; 01->11 is up
    drivePair(2'b11);
    check("R10 wrap to zero", 32'd0, 1'b0);
    preset(32'h7FFF_FFFF);
    drivePair(2'b10);
    check("R10 signed wrap", 32'h8000_0000, 1'b0);

    // R9: preset held while a step arrives, preset wins
    @(negedge clk);
    loadEn = 1'b1; loadValue = 32'd100;
    {chanA, chanB} = 2'b00;
    repeat (8) @(negedge clk);
    loadEn = 1'b0;
    @(negedge clk);
    check("R9 load priority", 32'd100, 1'b0);

    // R7: clear aligned with the edge where a double change is detected
    @(negedge clk);
    {chanA, chanB} = 2'b11;
    @(negedge clk);
    @(negedge clk);
    errClear = 1'b1;
    @(negedge clk);
    errClear = 1'b0;
    check("R7 set beats clear", 32'd100, 1'b1);
    repeat (4) @(negedge clk);
    pulseClear();
    check("R7 later clear", 32'd100, 1'b0);

    // R8: disabled, moves and a double change are ignored
    decodeEn = 1'b0;
    drivePair(2'b10);
    drivePair(2'b00);
    drivePair(2'b11);
    check("R8 disabled", 32'd100, 1'b0);
    decodeEn = 1'b1;
    repeat (8) @(negedge clk);
    check("R8 re-enabled no stale count", 32'd100, 1'b0);
    drivePair(2'b10);
    check("R8 counts after enable", 32'd101, 1'b0);

    // R11: slower sampling still counts spaced single steps
    divisor = DIV_W'(4);
    repeat (8) @(negedge clk);
    drivePair(2'b00);
    check("R11 divisor 4 step", 32'd102, 1'b0);
    drivePair(2'b01);
    check("R11 divisor 4 second step", 32'd103, 1'b0);
    divisor = '0;
    repeat (8) @(negedge clk);
    drivePair(2'b11);
    check("R11 divisor 0 step", 32'd104, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule